// File: doc/BRIEF.md
# Multi-Speed Data-Strobe Transmit Serializer

This block takes parallel words from a link-layer controller and sends them out as one serial stream, encoded as a data-strobe pair for the cable line drivers. A word is captured once per system-clock period. The per-packet speed code decides two things: how many lanes of the 8-bit input carry data (2, 4 or 8), and at what multiple of the system rate the bits leave (2x, 4x or 8x).

The design is clocked by the fastest bit clock, which is eight times the system rate. The system-clock edge on which words are captured reaches the block as a one-cycle enable pulse, `sys_ce`, that repeats every eight cycles. For the lower speeds, each bit is held on the output for two or four cycles. The strobe changes only when a data bit repeats the previous bit, so exactly one of the two wires moves per bit period. Dropping transmit enable, or raising power-down, forces both wires low and clears the encoder history.

Top module: `ds_tx_serializer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ds_data` and `ds_strobe` are both 0.
- R2: On any clock edge where `tx_en` is 0 or `pwr_down` is 1, both outputs become 0 on the next cycle. That edge also ends the packet and clears the encoder history to data=0, strobe=0.
- R3: While the block is active, data and strobe never change in the same cycle. At the start of every bit, exactly one of them toggles.
- R4: Speed code 2'b10 (highest speed) sends all 8 lanes of each captured word, one bit per cycle, in the order `link_d[7]`, `link_d[6]`, and so on down to `link_d[0]`.
- R5: Speed code 2'b01 (middle speed) sends only `link_d[7:4]`, in the order `link_d[7]` first, with each bit held for 2 cycles. `link_d[3:0]` has no effect on the outputs.
- R6: Speed code 2'b00 (lowest speed) sends only `link_d[7]` and then `link_d[6]`, each held for 4 cycles. `link_d[5:0]` has no effect on the outputs.
- R7: Speed code 2'b11 behaves exactly like 2'b00.
- R8: The speed code is sampled on the first `sys_ce` of a packet. A packet starts with the first `sys_ce` on which the block is active. Later values of the speed code are ignored until `tx_en` falls or `pwr_down` rises.
- R9: `link_d` is captured only on cycles where `sys_ce` is high. Changes to `link_d` on other cycles have no effect on the outputs.
- R10: The first bit of a captured word appears on `ds_data` on the cycle after the `sys_ce` that captured it.
- R11: Starting from a cleared history, a first bit of 0 raises the strobe, and a first bit of 1 raises data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock (8x system rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_ce | input | 1 | One-cycle pulse marking each system-clock capture edge |
| tx_en | input | 1 | Transmit enable; high for the length of a packet |
| pwr_down | input | 1 | Power-down; high disables transmission |
| speed | input | 2 | Speed code: 00 low, 01 middle, 10 high, 11 low |
| link_d | input | 8 | Parallel data from the link; bit 7 is sent first |
| ds_data | output | 1 | Encoded data wire |
| ds_strobe | output | 1 | Encoded strobe wire |

## Verification
The bound checker verifies the following on every cycle:
- Both wires go low after an inactive edge.
- Data and strobe never move together while active.
- The first bit of a word lands on `ds_data` one cycle after its capture.
- The latched speed stays stable for the whole packet.

Some behaviour can only be shown by the bench's reference model, which is compared on every cycle across directed and random packets:
- The lane order and bit holding time at each speed.
- The masking of unused lanes.
- The mapping of code 11 onto the lowest speed.
- The ignoring of `link_d` between capture pulses and of speed changes in mid-packet.

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sys_ce,
  input  logic         tx_en,
  input  logic         pwr_down,
  input  logic [1:0]   speed,
  input  logic [W-1:0] link_d,
  output logic         ds_data,
  output logic         ds_strobe
);
  localparam int PW = $clog2(W);

  logic         run_q;
  logic [1:0]   spd_q;
  logic [W-1:0] sh_q;
  logic [PW-1:0] ph_q;
  logic         d_q, s_q;
  logic         tick;

  wire active = tx_en & ~pwr_down;
  wire load   = active & sys_ce;
  wire [1:0] spd_in = (speed == 2'b11) ? 2'b00 : speed;

  always_comb begin
    case (spd_q)
      2'b10:   tick = 1'b1;
      2'b01:   tick = ~ph_q[0];
      default: tick = (ph_q[1:0] == 2'b00);
    endcase
  end

  wire emit = load | (active & run_q & tick);
  wire nbit = load ? link_d[W-1] : sh_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      spd_q <= 2'b00;
      sh_q  <= '0;
      ph_q  <= '0;
      d_q   <= 1'b0;
      s_q   <= 1'b0;
    end else if (!active) begin
      run_q <= 1'b0;
      spd_q <= 2'b00;
      sh_q  <= '0;
      ph_q  <= '0;
      d_q   <= 1'b0;
      s_q   <= 1'b0;
    end else begin
      if (load) begin
        sh_q <= link_d << 1;
        ph_q <= PW'(1);
        if (!run_q) begin
          run_q <= 1'b1;
          spd_q <= spd_in;
        end
      end else if (run_q) begin
        ph_q <= ph_q + 1'b1;
        if (tick) sh_q <= sh_q << 1;
      end
      if (emit) begin
        d_q <= nbit;
        if (nbit == d_q) s_q <= ~s_q;
      end
    end
  end

  assign ds_data   = d_q;
  assign ds_strobe = s_q;
endmodule

module ds_tx_serializer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sys_ce,
  input logic         tx_en,
  input logic         pwr_down,
  input logic [W-1:0] link_d,
  input logic         ds_data,
  input logic         ds_strobe,
  input logic         run_q,
  input logic [1:0]   spd_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ds_data && !ds_strobe)); // R1

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || pwr_down) |=> (!ds_data && !ds_strobe)); // R2

  AST_ONE_WIRE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !pwr_down) |=> !((ds_data != $past(ds_data)) && (ds_strobe != $past(ds_strobe)))); // R3

  AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(spd_q)); // R8

  AST_FIRST_BIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ce && tx_en && !pwr_down) |=> (ds_data == $past(link_d[W-1]))); // R10
endmodule

bind ds_tx_serializer ds_tx_serializer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .tx_en(tx_en), .pwr_down(pwr_down),
  .link_d(link_d), .ds_data(ds_data), .ds_strobe(ds_strobe),
  .run_q(run_q), .spd_q(spd_q)
);

// File: tb/ds_tx_serializer_bench.sv
`timescale 1ns/1ps
module ds_tx_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_ce = 1'b0;
  logic       tx_en = 1'b0;
  logic       pwr_down = 1'b0;
  logic [1:0] speed = 2'b00;
  logic [7:0] link_d = 8'h00;
  logic       ds_data, ds_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ds_tx_serializer u_ds_tx_serializer (
    .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .tx_en(tx_en), .pwr_down(pwr_down),
    .speed(speed), .link_d(link_d), .ds_data(ds_data), .ds_strobe(ds_strobe)
  );

  // Behavioural reference: a queue of bit entries (bit*2 + start-of-bit flag)
  int   q[$];
  bit   mrun;
  int   mspd;
  logic md, ms;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); mrun = 0; mspd = 0; md = 0; ms = 0;
    end else if (!tx_en || pwr_down) begin
      q.delete(); mrun = 0; md = 0; ms = 0;
    end else begin
      if (sys_ce) begin
        int n, hold;
        if (!mrun) begin
          mrun = 1;
          mspd = (speed == 2'b11) ? 0 : int'(speed);
        end
        n = (mspd == 2) ? 8 : (mspd == 1) ? 4 : 2;
        hold = 8 / n;
        q.delete();
        for (int i = 0; i < n; i++)
          for (int h = 0; h < hold; h++)
            q.push_back(int'(link_d[7-i]) * 2 + ((h == 0) ? 1 : 0));
      end
      if (q.size() > 0) begin
        int e;
        logic b;
        e = q.pop_front();
        if (e % 2 == 1) begin
          b = logic'(e / 2);
          if (b == md) ms = ~ms;
          md = b;
        end
      end
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (ds_data !== md || ds_strobe !== ms) begin
      fails++;
      $display("FAIL %s: data,strobe = %b,%b expected %b,%b at %0t",
               tag, ds_data, ds_strobe, md, ms, $time);
    end
  endtask

  task automatic word(input logic [7:0] d, input logic [1:0] sp, input string tag);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      compare(tag);
      sys_ce = (c == 0);
      link_d = (c == 0) ? d : 8'($urandom);
      speed  = (c == 0) ? sp : 2'($urandom);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare(tag);
      sys_ce = (c % 8 == 0);
      tx_en  = 1'b0;
      link_d = 8'($urandom);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ds_data !== 1'b0 || ds_strobe !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset data,strobe = %b,%b expected 0,0", ds_data, ds_strobe);
    end
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R11: cleared history, first bit 0 raises strobe
    tx_en = 1'b1;
    word(8'h00, 2'b10, "R11");
    word(8'hFF, 2'b10, "R4");
    word(8'hA5, 2'b10, "R4");
    word(8'h3C, 2'b10, "R4");
    idle(5, "R2");
    // R11: first bit 1 raises data
    tx_en = 1'b1;
    word(8'h80, 2'b10, "R11");
    idle(3, "R2");

    tx_en = 1'b1;
    word(8'hF0, 2'b01, "R5");
    word(8'h5A, 2'b01, "R5");
    word(8'h0F, 2'b01, "R5 lower lanes ignored");
    word(8'hA3, 2'b01, "R9");
    idle(4, "R2");

    tx_en = 1'b1;
    word(8'hC0, 2'b00, "R6");
    word(8'h40, 2'b00, "R6");
    word(8'h3F, 2'b00, "R6 lower lanes ignored");
    idle(4, "R2");

    tx_en = 1'b1;
    word(8'h80, 2'b11, "R7");
    word(8'h7F, 2'b11, "R7");
    idle(4, "R2");

    // R8: speed changes in mid-packet are ignored
    tx_en = 1'b1;
    word(8'h96, 2'b10, "R8");
    word(8'h69, 2'b00, "R8");
    word(8'hC3, 2'b01, "R8");
    idle(4, "R2");

    // R2: power-down in the middle of a packet
    tx_en = 1'b1;
    word(8'hE7, 2'b01, "R2");
    pwr_down = 1'b1;
    word(8'hFF, 2'b10, "R2");
    pwr_down = 1'b0;
    word(8'h81, 2'b10, "R2");
    idle(4, "R2");

    for (int p = 0; p < 40; p++) begin
      logic [1:0] sp;
      int len;
      sp  = 2'($urandom);
      len = 1 + ($urandom % 6);
      tx_en = 1'b1;
      for (int k = 0; k < len; k++) word(8'($urandom), (k == 0) ? sp : 2'($urandom), "R3");
      idle(1 + ($urandom % 9), "R2");
    end

    @(negedge clk);
    compare("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule